// File: doc/BRIEF.md
# Memory Request Stream Generator

This block produces a stream of request descriptors for exercising a packetized memory link during bandwidth and latency benchmarking. Software or a test harness sets a configuration (request block size, target read percentage, ordering style, addressing style, stride, base and wrap limit, and stream length) and pulses `start`. The block then offers one descriptor per accepted handshake. Each descriptor carries a read/write command, a byte address and a size code. When the requested number of descriptors has been accepted, it raises `done`.

Two ordering styles are available. Interleaved ordering spreads reads evenly through the stream at the target percentage. Grouped ordering places every read of the stream first and every write after them, so that the cost of poorly ordered traffic can be measured. Addresses advance linearly, by a stride counted in request blocks, or come from a pseudo-random sequence. A stride of 16 blocks under low-interleave mapping concentrates all traffic on a single vault.

Top module: `req_traffic_gen`

## Requirements
- R1: After reset `req_valid` and `done` are both 0.
- R2: A `start` pulse while no stream is running captures every `cfg_*` input, and the first descriptor is valid in the next cycle. A `start` pulse while a stream is running is ignored, and later descriptors still carry the captured configuration.
- R3: Exactly `cfg_len` descriptors are accepted (`req_valid && req_ready`). After that `req_valid` is 0 and `done` is 1 until the next `start`. With `cfg_len` = 0, `done` rises in the cycle after `start` and no descriptor is offered.
- R4: While `req_valid` is 1 and `req_ready` is 0, `req_write`, `req_addr` and `req_size` hold their values and `req_valid` stays 1.
- R5: Interleaved ordering (`cfg_grouped`=0). A sum starts at 0. For each descriptor the percentage is added to it. If the sum is 100 or more, the descriptor is a read (`req_write`=0) and 100 is subtracted. Otherwise it is a write (`req_write`=1).
- R6: Grouped ordering (`cfg_grouped`=1). Descriptor k (counting from 0) is a read exactly when (k+1)·100 ≤ len·pct. A 100-long stream at 53 % therefore gives 53 reads followed by 47 writes.
- R7: A read percentage above 100 is treated as 100, so every descriptor is a read.
- R8: `cfg_size` code c selects a block of (c+1)·16 bytes (16 to 128), and `req_size` carries the captured code.
- R9: Linear mode (`cfg_mode`=0). The first address is `cfg_base`, and each accepted descriptor advances the address by one block.
- R10: Strided mode (`cfg_mode`=1). Each accepted descriptor advances the address by `cfg_stride` × block bytes.
- R11: In linear and strided modes, an advanced address that is equal to or above `cfg_limit` is replaced by `cfg_base`.
- R12: Random mode (`cfg_mode`=2). A 32-bit register is set to 0xACE12025 on start. On each acceptance it shifts right, and it is XORed with 0x80200003 when the bit shifted out was 1. The address is this register with its low 4 bits cleared.
- R13: Mode code 3 behaves exactly as linear mode, and `cfg_stride` has no effect in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a stream when idle |
| cfg_len | input | LEN_W | Number of descriptors in the stream |
| cfg_size | input | 3 | Block size code, (c+1)·16 bytes |
| cfg_read_pct | input | 7 | Target read percentage, clamped at 100 |
| cfg_grouped | input | 1 | 1: all reads then all writes; 0: interleaved |
| cfg_mode | input | 2 | 0 linear, 1 strided, 2 random, 3 linear |
| cfg_stride | input | 8 | Stride in blocks for strided mode |
| cfg_base | input | AW | First and wrap-back address |
| cfg_limit | input | AW | Wrap limit address |
| req_valid | output | 1 | Descriptor available |
| req_ready | input | 1 | Consumer accepts the descriptor |
| req_write | output | 1 | 1 write, 0 read |
| req_addr | output | AW | Byte address |
| req_size | output | 3 | Block size code |
| done | output | 1 | Stream complete |

## Verification
The assertions assume that `start` is only meaningful when no stream is running. They also assume the consumer may hold `req_ready` low for any number of cycles. The bench keeps its `cfg_*` inputs steady around the `start` edge, with one deliberate exception: a restart with a different size that it issues mid-stream to confirm the block ignores it. It drives a random `req_ready` pattern in most runs so that back-pressure holds occur often. It keeps `cfg_limit` above `cfg_base` in the wrapping modes, so that the stream remains well defined.

// File: rtl/req_traffic_gen.sv
module req_traffic_gen #(
  parameter int AW    = 32,
  parameter int LEN_W = 16,
  parameter logic [31:0] SEED = 32'hACE1_2025,
  parameter logic [31:0] TAPS = 32'h8020_0003
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [2:0]       cfg_size,
  input  logic [6:0]       cfg_read_pct,
  input  logic             cfg_grouped,
  input  logic [1:0]       cfg_mode,
  input  logic [7:0]       cfg_stride,
  input  logic [AW-1:0]    cfg_base,
  input  logic [AW-1:0]    cfg_limit,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_write,
  output logic [AW-1:0]    req_addr,
  output logic [2:0]       req_size,
  output logic             done
);
  localparam int PW = LEN_W + 7;
  localparam logic [1:0] MODE_STRIDE = 2'd1;
  localparam logic [1:0] MODE_RANDOM = 2'd2;

  logic             busy_q, done_q, grouped_q, random_q;
  logic [LEN_W-1:0] len_q, cnt_q, cnt_nxt;
  logic [6:0]       pct_q, pct_eff;
  logic [7:0]       acc_q, acc_sum;
  logic [PW-1:0]    prod_q, thr_q;
  logic [2:0]       size_q;
  logic [AW-1:0]    step_q, base_q, limit_q, addr_q;
  logic [AW:0]      addr_sum;
  logic [31:0]      lfsr_q, lfsr_nxt, lfsr_masked;
  logic [7:0]       size_bytes, stride_eff;
  logic [15:0]      step_calc;
  logic             launch, fire, il_read, gr_read;

  assign launch     = start && !busy_q;
  assign fire       = busy_q && req_ready;
  assign pct_eff    = (cfg_read_pct > 7'd100) ? 7'd100 : cfg_read_pct;
  assign size_bytes = {1'b0, ({1'b0, cfg_size} + 4'd1), 3'b000} << 1;
  assign stride_eff = (cfg_mode == MODE_STRIDE) ? cfg_stride : 8'd1;
  assign step_calc  = {8'd0, stride_eff} * {8'd0, size_bytes};

  assign acc_sum  = acc_q + {1'b0, pct_q};
  assign il_read  = acc_sum >= 8'd100;
  assign gr_read  = thr_q <= prod_q;
  assign cnt_nxt  = cnt_q + 1'b1;
  assign addr_sum = {1'b0, addr_q} + {1'b0, step_q};
  assign lfsr_nxt = (lfsr_q >> 1) ^ (lfsr_q[0] ? TAPS : 32'd0);
  assign lfsr_masked = lfsr_q & ~32'hF;

  assign req_valid = busy_q;
  assign req_write = grouped_q ? !gr_read : !il_read;
  assign req_addr  = random_q ? lfsr_masked[AW-1:0] : addr_q;
  assign req_size  = size_q;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      grouped_q <= 1'b0;
      random_q  <= 1'b0;
      len_q     <= '0;
      cnt_q     <= '0;
      pct_q     <= '0;
      acc_q     <= '0;
      prod_q    <= '0;
      thr_q     <= '0;
      size_q    <= '0;
      step_q    <= '0;
      base_q    <= '0;
      limit_q   <= '0;
      addr_q    <= '0;
      lfsr_q    <= SEED;
    end else if (launch) begin
      busy_q    <= cfg_len != '0;
      done_q    <= cfg_len == '0;
      grouped_q <= cfg_grouped;
      random_q  <= cfg_mode == MODE_RANDOM;
      len_q     <= cfg_len;
      cnt_q     <= '0;
      pct_q     <= pct_eff;
      acc_q     <= '0;
      prod_q    <= PW'(cfg_len) * PW'(pct_eff);
      thr_q     <= PW'(100);
      size_q    <= cfg_size;
      step_q    <= AW'(step_calc);
      base_q    <= cfg_base;
      limit_q   <= cfg_limit;
      addr_q    <= cfg_base;
      lfsr_q    <= SEED;
    end else if (fire) begin
      cnt_q  <= cnt_nxt;
      acc_q  <= il_read ? acc_sum - 8'd100 : acc_sum;
      thr_q  <= thr_q + PW'(100);
      addr_q <= (addr_sum >= {1'b0, limit_q}) ? base_q : addr_sum[AW-1:0];
      lfsr_q <= lfsr_nxt;
      if (cnt_nxt == len_q) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end
endmodule

module req_traffic_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [2:0]    req_size,
  input logic          done
);
  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !req_valid |=> req_valid || done);

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_write) &&
                                $stable(req_addr) && $stable(req_size));
endmodule

bind req_traffic_gen req_traffic_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
  .req_size(req_size), .done(done)
);

// File: tb/tb_req_traffic_gen.sv
module tb_req_traffic_gen;
  localparam int AW = 32;
  localparam int LEN_W = 16;

  logic clk = 0, rst_n = 0, start = 0, req_ready = 0;
  logic [LEN_W-1:0] cfg_len = 0;
  logic [2:0] cfg_size = 0;
  logic [6:0] cfg_read_pct = 0;
  logic cfg_grouped = 0;
  logic [1:0] cfg_mode = 0;
  logic [7:0] cfg_stride = 0;
  logic [AW-1:0] cfg_base = 0, cfg_limit = 0;
  logic req_valid, req_write, done;
  logic [AW-1:0] req_addr;
  logic [2:0] req_size;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  req_traffic_gen #(.AW(AW), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len),
    .cfg_size(cfg_size), .cfg_read_pct(cfg_read_pct), .cfg_grouped(cfg_grouped),
    .cfg_mode(cfg_mode), .cfg_stride(cfg_stride), .cfg_base(cfg_base),
    .cfg_limit(cfg_limit), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size), .done(done)
  );

  // behavioural reference model
  bit m_busy, m_done, m_grp;
  int m_len, m_cnt, m_pct, m_acc, m_mode, m_size;
  longint m_step, m_base, m_limit, m_addr;
  bit [31:0] m_lfsr;

  function automatic bit m_is_write();
    if (m_grp) return !((m_cnt + 1) * 100 <= m_len * m_pct);
    return !(m_acc + m_pct >= 100);
  endfunction

  function automatic longint m_cur_addr();
    if (m_mode == 2) return longint'(m_lfsr & 32'hFFFF_FFF0);
    return m_addr;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0;
    end else if (start && !m_busy) begin
      m_len   = int'(cfg_len);
      m_pct   = (cfg_read_pct > 100) ? 100 : int'(cfg_read_pct);
      m_grp   = cfg_grouped;
      m_mode  = int'(cfg_mode);
      m_size  = int'(cfg_size);
      m_step  = longint'((cfg_mode == 1) ? cfg_stride : 1) * (m_size + 1) * 16;
      m_base  = longint'(cfg_base);
      m_limit = longint'(cfg_limit);
      m_addr  = m_base;
      m_lfsr  = 32'hACE1_2025;
      m_cnt   = 0;
      m_acc   = 0;
      m_busy  <= (m_len != 0);
      m_done  <= (m_len == 0);
    end else if (m_busy && req_ready) begin
      if (m_acc + m_pct >= 100) m_acc = m_acc + m_pct - 100;
      else m_acc = m_acc + m_pct;
      m_addr = m_addr + m_step;
      if (m_addr >= m_limit) m_addr = m_base;
      m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? 32'h8020_0003 : 32'd0);
      m_cnt = m_cnt + 1;
      if (m_cnt == m_len) begin
        m_busy <= 0; m_done <= 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string addr_tag();
    case (m_mode)
      0: return "R9 linear address";
      1: return "R10/R11 strided address";
      2: return "R12 random address";
      default: return "R13 mode3 address";
    endcase
  endfunction

  int run_reads, run_fires;

  task automatic cycle();
    bit fire_rd, fire_any, hold;
    logic w0; logic [AW-1:0] a0; logic [2:0] s0;
    fire_any = req_valid && req_ready;
    fire_rd  = fire_any && !req_write;
    hold = req_valid && !req_ready;
    w0 = req_write; a0 = req_addr; s0 = req_size;
    @(negedge clk);
    if (fire_any) run_fires++;
    if (fire_rd) run_reads++;
    chk(req_valid == m_busy, "R3 valid", req_valid, m_busy);
    chk(done == m_done, "R3 done", done, m_done);
    if (m_busy && req_valid) begin
      chk(req_write == m_is_write(), m_grp ? "R6 grouped cmd" : "R5 interleaved cmd",
          req_write, m_is_write());
      chk(req_size == 3'(m_size), "R8 size", req_size, m_size);
      chk(longint'(req_addr) == m_cur_addr(), addr_tag(), req_addr, m_cur_addr());
    end
    if (hold) begin
      chk(req_valid && req_write == w0 && req_addr == a0 && req_size == s0,
          "R4 hold", req_addr, a0);
    end
  endtask

  task automatic run(input int len, input int size, input int pct, input bit grp,
                     input int mode, input int stride, input longint base,
                     input longint limit, input bit rnd_ready, input bit restart);
    run_reads = 0; run_fires = 0;
    cfg_len = LEN_W'(len); cfg_size = 3'(size); cfg_read_pct = 7'(pct);
    cfg_grouped = grp; cfg_mode = 2'(mode); cfg_stride = 8'(stride);
    cfg_base = AW'(base); cfg_limit = AW'(limit);
    start = 1; req_ready = rnd_ready ? ($urandom % 10 < 6) : 1'b1;
    cycle();
    start = 0;
    for (int i = 0; i < 5000 && !m_done; i++) begin
      req_ready = rnd_ready ? ($urandom % 10 < 6) : 1'b1;
      if (restart && i == 3) begin
        start = 1; cfg_size = 3'(size ^ 1); cfg_len = 16'd1;
      end
      cycle();
      if (restart && i == 3) begin
        start = 0;
        // R2: restart while busy ignored
        chk(!req_valid || req_size == 3'(size), "R2 busy restart", req_size, size);
      end
    end
    req_ready = 0;
    chk(run_fires == len, "R3 accepted count", run_fires, len);
    cycle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_valid == 0, "R1 reset valid", req_valid, 0);
    chk(done == 0, "R1 reset done", done, 0);
    rst_n = 1;
    @(negedge clk);
    // R5 R9: interleaved linear 128 B
    run(20, 7, 53, 0, 0, 0, 'h1000, 'h10_0000, 0, 0);
    chk(run_reads == 10, "R5 read count", run_reads, 10);
    // R6: grouped, 100 requests at 53 %
    run(100, 7, 53, 1, 0, 0, 'h0, 'h100_0000, 1, 0);
    chk(run_reads == 53, "R6 grouped read count", run_reads, 53);
    // R10 R11: stride 16 of 64 B blocks, wrap every 4
    run(12, 3, 40, 0, 1, 16, 'h1000, 'h2000, 1, 0);
    // R12: random addresses
    run(16, 1, 66, 0, 2, 0, 'h0, 'h0, 1, 0);
    // R7: percentage above 100
    run(15, 0, 120, 0, 0, 0, 'h0, 'h1_0000, 1, 0);
    chk(run_reads == 15, "R7 all reads", run_reads, 15);
    // R3: empty stream
    run(0, 2, 50, 0, 0, 0, 'h0, 'h1_0000, 0, 0);
    chk(done == 1 && req_valid == 0, "R3 empty stream done", done, 1);
    // R13: mode 3 ignores stride
    run(10, 4, 55, 1, 3, 5, 'h200, 'h600, 1, 0);
    // R2: restart while busy
    run(12, 2, 57, 0, 0, 0, 'h40, 'h8000, 1, 1);
    // R8: 48 B writes only
    run(9, 2, 0, 0, 0, 0, 'h30, 'h1_0000, 0, 0);
    chk(run_reads == 0, "R8 write-only stream", run_reads, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule